// File: doc/BRIEF.md
# Host Sequencer for a Half-Flash Converter

This block is the host-side controller that drives the chip-select, write and read strobes of an 8-bit half-flash analog-to-digital converter with a parallel output bus. A one-cycle start request with a mode code launches one conversion. The code picks one of three ways to collect the result. In read-strobe mode, chip select and read are held low until the converter releases its ready line. In write-interrupt mode, a write pulse is followed by a wait for the converter's active-low interrupt and then a read pulse. In write-early mode, the read pulse follows the write pulse after a fixed delay and does not wait for the interrupt.

The captured data byte and the overflow flag go into a result register, together with a single-cycle valid pulse. Every time value is given in nanoseconds and converted to clock cycles with rounding up. These values are the write-strobe width, the early-read delay, the read access time, the recovery gap between conversions and the response timeout. If the interrupt or ready line does not respond in time, the conversion is abandoned with a one-cycle error pulse.

Top module: `cnv_host_ctrl`

## Requirements
- R1: During and after reset, before any start, `cvt_cs_n`, `cvt_wr_n` and `cvt_rd_n` are high and `busy_o`, `res_valid_o` and `err_o` are low.
- R2: `start_i` is accepted only while `busy_o` is low. Mode code 2'b00 selects read-strobe, 2'b01 write-interrupt and 2'b10 write-early. Code 2'b11, and any start while busy, leave all strobes and outputs unchanged.
- R3: In both write modes, `cvt_wr_n` is low with `cvt_cs_n` low for exactly ceil(WR_MIN_NS/period) cycles, and never more than ceil(WR_MAX_NS/period) cycles.
- R4: In write-interrupt mode, after `cvt_wr_n` rises the controller waits until `cvt_int_n` is low before it drives `cvt_rd_n` low. It then holds `cvt_rd_n` low for ceil(ACCESS_NS/period) cycles and captures the bus on the last of those cycles.
- R5: In write-early mode, `cvt_rd_n` falls ceil(EARLY_NS/period) cycles after `cvt_wr_n` rises, whatever the level of `cvt_int_n`. It stays low for the access time of R4, and the capture rule of R4 applies.
- R6: In read-strobe mode, `cvt_cs_n` and `cvt_rd_n` fall together and stay low. The bus is captured on the first cycle, at least ceil(ACCESS_NS/period) cycles into the strobe, on which `cvt_rdy_n` is high.
- R7: A capture loads `res_data_o` with `cvt_data_i` and `res_ofl_o` with the inverse of the active-low `cvt_ofl_n_i`. `res_valid_o` is high for exactly one cycle per completed conversion, and the result holds its value until the next capture.
- R8: Between the release of `cvt_cs_n` and the next fall of `cvt_cs_n`, at least ceil(RECOVER_NS/period) cycles pass. `busy_o` stays high until `cvt_int_n` has been seen high.
- R9: If `cvt_int_n` (write-interrupt wait or recovery) or `cvt_rdy_n` (read-strobe) does not respond within ceil(TIMEOUT_NS/period) cycles, the conversion is abandoned. `err_o` pulses for one cycle, no valid pulse is produced, and the controller returns to idle.
- R10: `cvt_wr_n` and `cvt_rd_n` are never low at the same time, and neither is low while `cvt_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, one cycle |
| mode_i | input | 2 | Read strategy for this request |
| cvt_cs_n | output | 1 | Converter chip select, active low |
| cvt_wr_n | output | 1 | Converter write/start strobe, active low |
| cvt_rd_n | output | 1 | Converter read strobe, active low |
| cvt_int_n | input | 1 | Converter end-of-conversion interrupt, active low |
| cvt_rdy_n | input | 1 | Converter ready line, low while busy, high when released |
| cvt_data_i | input | DATA_W | Converter data bus |
| cvt_ofl_n_i | input | 1 | Converter overflow, active low |
| busy_o | output | 1 | Conversion or recovery in progress |
| res_data_o | output | DATA_W | Captured conversion result |
| res_ofl_o | output | 1 | Captured overflow, active high |
| res_valid_o | output | 1 | One-cycle pulse when a new result is loaded |
| err_o | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The bound checker watches on every cycle the properties that concern the strobes alone. These are the write-pulse width bounds, the recovery gap before each chip-select fall, the mutual exclusion of write and read, and the rule that no strobe goes low without chip select. It also checks the single-cycle valid pulse, the result holding between captures, and that idle is never re-entered while the interrupt is low unless an error is flagged. The ordering of the read strobe against the interrupt, and the exact early-read delay and access time, can be shown only by the bench. The same holds for the byte and overflow actually captured, the rejection of illegal or overlapping starts, and the timeout paths. The bench shows these with a behavioural converter that drives the wrong value on the bus except inside the legal capture window.

// File: rtl/cnv_host_pkg.sv
`timescale 1ns/1ps
package cnv_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WINT,
    ST_GAP,
    ST_RD,
    ST_RDM,
    ST_REC
  } cnv_st_e;

  localparam logic [1:0] MD_READ     = 2'b00;
  localparam logic [1:0] MD_WR_INT   = 2'b01;
  localparam logic [1:0] MD_WR_EARLY = 2'b10;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/cnv_step_timer.sv
`timescale 1ns/1ps
module cnv_step_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i || (cnt_q != CNT_MAX);
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cnv_seq_fsm.sv
`timescale 1ns/1ps
module cnv_seq_fsm
  import cnv_host_pkg::*;
#(
  parameter int unsigned CW       = 10,
  parameter int unsigned WR_CYC   = 120,
  parameter int unsigned EARLY_CYC = 120,
  parameter int unsigned ACC_CYC  = 70,
  parameter int unsigned REC_CYC  = 100,
  parameter int unsigned TO_CYC   = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          int_n_i,
  input  logic          rdy_n_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clear_o,
  output logic          sample_o,
  output logic          err_set_o,
  output cnv_st_e       st_o
);

  localparam logic [CW-1:0] WR_LAST    = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] EARLY_LAST = CW'(EARLY_CYC - 1);
  localparam logic [CW-1:0] ACC_LAST   = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] TO_LAST    = CW'(TO_CYC - 1);

  cnv_st_e    st_q, st_d;
  logic [1:0] mode_q;
  logic       accept;

  // next-state decode
  always_comb begin
    st_d      = st_q;
    sample_o  = 1'b0;
    err_set_o = 1'b0;
    accept    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i && (mode_i != 2'b11)) begin
          accept = 1'b1;
          st_d   = (mode_i == MD_READ) ? ST_RDM : ST_WR;
        end
      end
      ST_WR: begin
        if (cnt_i == WR_LAST) begin
          st_d = (mode_q == MD_WR_INT) ? ST_WINT : ST_GAP;
        end
      end
      ST_WINT: begin
        if (!int_n_i) begin
          st_d = ST_RD;
        end else if (cnt_i == TO_LAST) begin
          err_set_o = 1'b1;
          st_d      = ST_REC;
        end
      end
      ST_GAP: begin
        if (cnt_i == EARLY_LAST) begin
          st_d = ST_RD;
        end
      end
      ST_RD: begin
        if (cnt_i == ACC_LAST) begin
          sample_o = 1'b1;
          st_d     = ST_REC;
        end
      end
      ST_RDM: begin
        if ((cnt_i >= ACC_LAST) && rdy_n_i) begin
          sample_o = 1'b1;
          st_d     = ST_REC;
        end else if (cnt_i == TO_LAST) begin
          err_set_o = 1'b1;
          st_d      = ST_REC;
        end
      end
      ST_REC: begin
        if ((cnt_i >= REC_LAST) && int_n_i) begin
          st_d = ST_IDLE;
        end else if (cnt_i == TO_LAST) begin
          err_set_o = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    clear_o = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
    end else if (accept) begin
      mode_q <= mode_i;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/cnv_result_reg.sv
`timescale 1ns/1ps
module cnv_result_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              err_set_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ofl_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ofl_o,
  output logic              valid_o,
  output logic              err_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      ofl_o  <= 1'b0;
    end else if (sample_i) begin
      data_o <= data_i;
      ofl_o  <= ~ofl_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= sample_i;
      err_o   <= err_set_i;
    end
  end

endmodule

// File: rtl/cnv_host_ctrl.sv
`timescale 1ns/1ps
module cnv_host_ctrl
  import cnv_host_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned WR_MIN_NS     = 600,
  parameter int unsigned WR_MAX_NS     = 50000,
  parameter int unsigned EARLY_NS      = 600,
  parameter int unsigned ACCESS_NS     = 350,
  parameter int unsigned RECOVER_NS    = 500,
  parameter int unsigned TIMEOUT_NS    = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  output logic              cvt_cs_n,
  output logic              cvt_wr_n,
  output logic              cvt_rd_n,
  input  logic              cvt_int_n,
  input  logic              cvt_rdy_n,
  input  logic [DATA_W-1:0] cvt_data_i,
  input  logic              cvt_ofl_n_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_ofl_o,
  output logic              res_valid_o,
  output logic              err_o
);

  localparam int unsigned WR_CYC    = ns_to_cyc(WR_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned EARLY_CYC = ns_to_cyc(EARLY_NS, CLK_PERIOD_PS);
  localparam int unsigned ACC_CYC   = ns_to_cyc(ACCESS_NS, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC   = ns_to_cyc(RECOVER_NS, CLK_PERIOD_PS);
  localparam int unsigned TO_CYC    = ns_to_cyc(TIMEOUT_NS, CLK_PERIOD_PS);
  // the timeout is the longest interval the counter has to reach
  localparam int unsigned CW        = $clog2(TO_CYC + 1);

  logic          clear;
  logic          sample;
  logic          err_set;
  logic [CW-1:0] cnt;
  cnv_st_e       st;

  cnv_step_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear),
    .cnt_o   (cnt)
  );

  cnv_seq_fsm #(
    .CW        (CW),
    .WR_CYC    (WR_CYC),
    .EARLY_CYC (EARLY_CYC),
    .ACC_CYC   (ACC_CYC),
    .REC_CYC   (REC_CYC),
    .TO_CYC    (TO_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .int_n_i   (cvt_int_n),
    .rdy_n_i   (cvt_rdy_n),
    .cnt_i     (cnt),
    .clear_o   (clear),
    .sample_o  (sample),
    .err_set_o (err_set),
    .st_o      (st)
  );

  cnv_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample),
    .err_set_i (err_set),
    .data_i    (cvt_data_i),
    .ofl_n_i   (cvt_ofl_n_i),
    .data_o    (res_data_o),
    .ofl_o     (res_ofl_o),
    .valid_o   (res_valid_o),
    .err_o     (err_o)
  );

  // strobes decoded from the state register only
  always_comb begin
    cvt_cs_n = (st == ST_IDLE) || (st == ST_REC);
    cvt_wr_n = (st != ST_WR);
    cvt_rd_n = (st != ST_RD) && (st != ST_RDM);
    busy_o   = (st != ST_IDLE);
  end

endmodule

// File: rtl/cnv_host_ctrl_chk.sv
`timescale 1ns/1ps
module cnv_host_ctrl_chk
  import cnv_host_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned WR_MIN_NS     = 600,
  parameter int unsigned WR_MAX_NS     = 50000,
  parameter int unsigned RECOVER_NS    = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cvt_cs_n,
  input logic              cvt_wr_n,
  input logic              cvt_rd_n,
  input logic              cvt_int_n,
  input logic              busy_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              res_valid_o,
  input logic              err_o
);

  localparam int unsigned T_WR    = ns_to_cyc(WR_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned T_WRMAX = ns_to_cyc(WR_MAX_NS, CLK_PERIOD_PS);
  localparam int unsigned T_REC   = ns_to_cyc(RECOVER_NS, CLK_PERIOD_PS);
  localparam int unsigned WCW     = $clog2(T_WRMAX + 2);
  localparam int unsigned RCW     = $clog2(T_REC + 1);

  logic [WCW-1:0] wr_lo_cnt;
  logic [RCW-1:0] cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lo_cnt <= '0;
    end else if (cvt_wr_n) begin
      wr_lo_cnt <= '0;
    end else if (wr_lo_cnt != {WCW{1'b1}}) begin
      wr_lo_cnt <= wr_lo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hi_cnt <= RCW'(T_REC);
    end else if (!cvt_cs_n) begin
      cs_hi_cnt <= '0;
    end else if (cs_hi_cnt != RCW'(T_REC)) begin
      cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end
  end

  // R3
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cvt_wr_n) |-> (wr_lo_cnt >= WCW'(T_WR)) && (wr_lo_cnt <= WCW'(T_WRMAX)));

  // R8
  recov_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cvt_cs_n) |-> (cs_hi_cnt >= RCW'(T_REC)));

  // R8
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (err_o || $past(cvt_int_n)));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cvt_wr_n && !cvt_rd_n));

  // R10
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cvt_wr_n || !cvt_rd_n) |-> !cvt_cs_n);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> $stable(res_data_o));

  // R9
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && res_valid_o));

endmodule

bind cnv_host_ctrl cnv_host_ctrl_chk #(
  .DATA_W        (DATA_W),
  .CLK_PERIOD_PS (CLK_PERIOD_PS),
  .WR_MIN_NS     (WR_MIN_NS),
  .WR_MAX_NS     (WR_MAX_NS),
  .RECOVER_NS    (RECOVER_NS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cvt_cs_n    (cvt_cs_n),
  .cvt_wr_n    (cvt_wr_n),
  .cvt_rd_n    (cvt_rd_n),
  .cvt_int_n   (cvt_int_n),
  .busy_o      (busy_o),
  .res_data_o  (res_data_o),
  .res_valid_o (res_valid_o),
  .err_o       (err_o)
);

// File: tb/cnv_host_ctrl_bench.sv
`timescale 1ns/1ps
module cnv_host_ctrl_bench;

  localparam int P         = 5000;
  localparam int T_WR      = (600 * 1000 + P - 1) / P;
  localparam int T_EARLY   = (600 * 1000 + P - 1) / P;
  localparam int T_ACC     = (350 * 1000 + P - 1) / P;
  localparam int T_REC     = (500 * 1000 + P - 1) / P;
  localparam int TI_CYC    = 160;
  localparam int ACC_MODEL = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       cvt_cs_n, cvt_wr_n, cvt_rd_n, cvt_int_n, cvt_rdy_n, cvt_ofl_n_i;
  logic [7:0] cvt_data_i;
  logic       busy_o, res_ofl_o, res_valid_o, err_o;
  logic [7:0] res_data_o;

  always #2.5 clk = ~clk;

  cnv_host_ctrl u_cnv_host_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .cvt_cs_n(cvt_cs_n), .cvt_wr_n(cvt_wr_n), .cvt_rd_n(cvt_rd_n),
    .cvt_int_n(cvt_int_n), .cvt_rdy_n(cvt_rdy_n), .cvt_data_i(cvt_data_i),
    .cvt_ofl_n_i(cvt_ofl_n_i), .busy_o(busy_o), .res_data_o(res_data_o),
    .res_ofl_o(res_ofl_o), .res_valid_o(res_valid_o), .err_o(err_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // converter model controls
  int       m_mode  = 0;
  logic [7:0] m_val = 8'h00;
  logic     m_ofl   = 1'b0;
  bit       m_int_en = 1'b1;
  int       m_rconv = 300;
  int       m_hold  = 0;

  logic int_r = 1'b1, rdy_r = 1'b1, ti_run = 1'b0, rm_done = 1'b0;
  logic prev_cs = 1'b1, prev_wr = 1'b1, prev_rd = 1'b1;
  int   ti_cnt = 0, rd_cnt = 0, hold_cnt = 0;
  logic data_ok;

  assign cvt_int_n   = int_r;
  assign cvt_rdy_n   = rdy_r;
  assign data_ok     = !cvt_rd_n && ((m_mode == 0) ? rm_done : (rd_cnt >= ACC_MODEL));
  assign cvt_data_i  = data_ok ? m_val : ~m_val;
  assign cvt_ofl_n_i = data_ok ? ~m_ofl : m_ofl;

  always @(negedge clk) begin
    prev_cs <= cvt_cs_n;
    prev_wr <= cvt_wr_n;
    prev_rd <= cvt_rd_n;
    if (cvt_rd_n) rd_cnt <= 0;
    else rd_cnt <= rd_cnt + 1;
    if (!prev_wr && cvt_wr_n && !cvt_cs_n) begin
      ti_run <= 1'b1;
      ti_cnt <= 0;
    end else if (ti_run) begin
      if (!cvt_rd_n || ti_cnt == TI_CYC - 1) begin
        ti_run <= 1'b0;
        if (m_int_en) int_r <= 1'b0;
      end else ti_cnt <= ti_cnt + 1;
    end
    if (cvt_cs_n) begin
      rm_done <= 1'b0;
      rdy_r   <= 1'b1;
    end else if (m_mode == 0 && !cvt_rd_n) begin
      if (rd_cnt >= m_rconv) begin
        rm_done <= 1'b1;
        rdy_r   <= 1'b1;
        int_r   <= 1'b0;
      end else rdy_r <= 1'b0;
    end
    if ((!prev_rd && cvt_rd_n) || (!prev_cs && cvt_cs_n)) begin
      if (m_hold == 0) int_r <= 1'b1;
      else hold_cnt <= m_hold;
    end else if (hold_cnt > 0) begin
      hold_cnt <= hold_cnt - 1;
      if (hold_cnt == 1) int_r <= 1'b1;
    end
  end

  // strobe monitor
  int wr_run = 0, last_wr_w = 0, since_wr = 0, last_gap = 0;
  int rd_run = 0, last_rd_w = 0, cs_run = 0, min_cs_gap = 1 << 30, cs_falls = 0;
  logic last_rd_int = 1'b1;
  bit   seen_cs = 1'b0;

  always @(negedge clk) begin
    if (!cvt_wr_n) wr_run <= wr_run + 1;
    else if (!prev_wr) begin last_wr_w <= wr_run; wr_run <= 0; end
    if (!prev_wr && cvt_wr_n) since_wr <= 1;
    else since_wr <= since_wr + 1;
    if (prev_rd && !cvt_rd_n) begin last_gap <= since_wr; last_rd_int <= cvt_int_n; end
    if (!cvt_rd_n) rd_run <= rd_run + 1;
    else if (!prev_rd) begin last_rd_w <= rd_run; rd_run <= 0; end
    if (cvt_cs_n) cs_run <= cs_run + 1;
    else if (prev_cs) begin
      if (seen_cs && cs_run < min_cs_gap) min_cs_gap <= cs_run;
      seen_cs  <= 1'b1;
      cs_falls <= cs_falls + 1;
      cs_run   <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  // one conversion; returns after the cycle following valid or error
  task automatic conv(input int md, input logic [7:0] v, input logic of,
                      input bit exp_err, input bit mid_start);
    bit got_v, got_e;
    int falls0;
    wait_idle();
    m_mode = md; m_val = v; m_ofl = of;
    falls0 = cs_falls;
    mode_i = 2'(md); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got_v = 1'b0; got_e = 1'b0;
    for (int n = 0; n < 4000 && !got_v && !got_e; n++) begin
      @(negedge clk);
      if (mid_start && n == 20) begin
        start_i = 1'b1; mode_i = 2'b00;
      end else start_i = 1'b0;
      got_v = res_valid_o;
      got_e = err_o;
    end
    start_i = 1'b0;
    if (exp_err) begin
      // R9 error pulse, no result
      chk(got_e && !got_v, "R9 error pulse", int'(got_e), 1);
      @(negedge clk);
      chk(!err_o, "R9 error one cycle", int'(err_o), 0);
      wait_idle();
      chk(!res_valid_o && !busy_o, "R9 return idle", int'(busy_o), 0);
      return;
    end
    chk(got_v, "R7 valid seen", int'(got_v), 1);
    chk(res_data_o == v, "R7 data", int'(res_data_o), int'(v));
    chk(res_ofl_o == of, "R7 overflow", int'(res_ofl_o), int'(of));
    @(negedge clk);
    chk(!res_valid_o, "R7 valid one cycle", int'(res_valid_o), 0);
    chk(res_data_o == v, "R7 result held", int'(res_data_o), int'(v));
    chk(cs_falls - falls0 == 1, "R2 one cs per start", cs_falls - falls0, 1);
    if (md != 0) begin
      chk(last_wr_w == T_WR, "R3 wr width", last_wr_w, T_WR);
      chk(last_rd_w == T_ACC, "R4 rd width", last_rd_w, T_ACC);
    end
    if (md == 1) chk(last_rd_int == 1'b0, "R4 rd after int", int'(last_rd_int), 0);
    if (md == 2) begin
      chk(last_gap == T_EARLY, "R5 early gap", last_gap, T_EARLY);
      chk(last_rd_int == 1'b1, "R5 no int wait", int'(last_rd_int), 1);
    end
    if (md == 0) chk(last_rd_w >= T_ACC, "R6 rd held", last_rd_w, T_ACC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 strobes idle in reset
    chk(cvt_cs_n && cvt_wr_n && cvt_rd_n, "R1 strobes in reset", int'({cvt_cs_n, cvt_wr_n, cvt_rd_n}), 7);
    chk(!busy_o && !res_valid_o && !err_o, "R1 flags in reset", int'({busy_o, res_valid_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cvt_cs_n && cvt_wr_n && cvt_rd_n, "R1 strobes after reset", int'({cvt_cs_n, cvt_wr_n, cvt_rd_n}), 7);
    chk(!busy_o, "R1 idle after reset", int'(busy_o), 0);

    // R2 reserved mode code ignored
    mode_i = 2'b11; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy_o && cvt_cs_n && cs_falls == 0, "R2 mode 11 ignored", cs_falls, 0);

    // sweep of all three strategies over spread data values
    for (int md = 0; md < 3; md++) begin
      for (int i = 0; i < 16; i++) begin
        conv(md, 8'((i * 17 + md * 3) & 8'hFF), 1'(i & 1), 1'b0, 1'b0);
      end
    end

    // R2 start during a busy write conversion ignored
    conv(2, 8'hA5, 1'b1, 1'b0, 1'b1);
    conv(1, 8'h3C, 1'b0, 1'b0, 1'b1);

    // R8 recovery gap seen over all conversions above
    chk(min_cs_gap >= T_REC, "R8 recovery gap", min_cs_gap, T_REC);

    // R8 interrupt held low after the read keeps the controller busy
    m_hold = 400;
    conv(1, 8'h81, 1'b1, 1'b0, 1'b0);
    m_hold = 0;
    repeat (200) @(negedge clk);
    chk(busy_o, "R8 wait for int release", int'(busy_o), 1);
    wait_idle();
    chk(!err_o && cvt_int_n, "R8 idle after int release", int'(cvt_int_n), 1);

    // R9 interrupt never asserted in write-interrupt mode
    m_int_en = 1'b0;
    conv(1, 8'h55, 1'b0, 1'b1, 1'b0);
    m_int_en = 1'b1;
    // R9 ready never released in read-strobe mode
    m_rconv = 100000;
    conv(0, 8'h66, 1'b0, 1'b1, 1'b0);
    m_rconv = 300;
    // recovery after an error: normal conversion works again
    conv(0, 8'hC3, 1'b1, 1'b0, 1'b0);
    chk(min_cs_gap >= T_REC, "R8 recovery gap final", min_cs_gap, T_REC);

    finish_run();
  end

endmodule